// File: doc/BRIEF.md
# Trigger Candidate Output Word Formatter

This block turns each of four winning trigger candidates into one 32-bit word for a downstream combiner. For every candidate it looks up three writable tables. The first maps the candidate's 7-bit rank and its valid flag to a 5-bit transverse momentum and a 3-bit quality. The second maps the 5-bit local phi and the 4-bit source identifier to an 8-bit global phi. The third maps the 5-bit local eta and the same source identifier to a 6-bit global eta. The results are packed with a halo flag, a sign bit, the valid flag, a 3-bit crossing count, a crossing-zero marker, a sync-error flag and two framing bits. The packed word leaves on a fixed layout one clock period after the lookup.

A two-state mode machine controls the block. In `ST_SETUP`, software loads the tables through a write port that selects a table and gives an address and data. Candidate strobes are ignored in this state. Transition `GO_TRIGGER` is taken on the first edge that sees `trig_mode_i` high, and the block moves to `ST_TRIGGER`. In that state candidates are converted and every table write is dropped. Transition `GO_SETUP` is taken when `trig_mode_i` falls, and the block returns to `ST_SETUP`. One shared 3-bit crossing counter advances every clock and restarts at zero on the crossing-zero marker.

Top module: `lut_word_formatter`

## Requirements
- R1: During and just after reset, `out_stb_o` is 0, every output word is 0, and the block is in setup mode.
- R2: The block enters trigger mode on the first rising edge that samples `trig_mode_i`=1, and leaves it on the first edge that samples 0. Table writes take effect only in setup mode; a write issued in trigger mode leaves the table unchanged.
- R3: `wr_sel_i` chooses the table to write: 0 = momentum/quality table (address bits 7..0), 1 = phi table (address bits 8..0), 2 = eta table (address bits 8..0, data bits 5..0). Select value 3 writes nothing.
- R4: The momentum/quality table address is {valid, rank}, with valid on bit 7. Its data gives momentum on bits 4..0 and quality on bits 7..5.
- R5: The phi table address is {source ID, local phi}, and the eta table address is {source ID, local eta}, with source ID on bits 8..5 in both.
- R6: Output word layout: phi in bits 7..0, momentum in 12..8, quality in 15..13, eta in 21..16, halo in 22, sign in 23, valid in 24, crossing count in 27..25, crossing-zero marker in 28, sync error in 29.
- R7: In trigger mode, candidates presented with `in_valid_i`=1 at a rising edge appear on `out_word_o` two rising edges after that edge. `out_stb_o` is high for exactly that one cycle. In setup mode `in_valid_i` produces no strobe.
- R8: When a candidate's valid flag is 0, bits 24..0 of its word are all 0. Bits 31..25 are still filled.
- R9: The crossing count in a word is 0 when `bc0_i` was high at the accepting edge. Otherwise it is the previous cycle's count plus one, modulo 8. It is 0 at the first edge after reset.
- R10: Bit 31 of every emitted word is 1 and bit 30 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one crossing per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_mode_i | input | 1 | 1 requests trigger mode, 0 requests setup mode |
| wr_en_i | input | 1 | Table write strobe |
| wr_sel_i | input | 2 | Table select (R3) |
| wr_addr_i | input | 9 | Table write address |
| wr_data_i | input | 8 | Table write data |
| bc0_i | input | 1 | Crossing-zero marker for this cycle |
| sync_err_i | input | 1 | Sync error flag for this cycle |
| in_valid_i | input | 1 | Candidate set present |
| cand_rank_i | input | 28 | Four 7-bit ranks, candidate k at bits 7k+6..7k |
| cand_vld_i | input | 4 | Per-candidate valid flag |
| cand_phi_i | input | 20 | Four 5-bit local phi values |
| cand_eta_i | input | 20 | Four 5-bit local eta values |
| cand_sid_i | input | 16 | Four 4-bit source IDs |
| cand_halo_i | input | 4 | Per-candidate halo flag |
| cand_sign_i | input | 4 | Per-candidate sign bit |
| out_stb_o | output | 1 | Output words valid this cycle |
| out_word_o | output | 128 | Four 32-bit words, candidate k at bits 32k+31..32k |

## Verification
The bench builds the block with its default parameters: four candidates, full-size tables of 256, 512 and 512 entries, and a 3-bit crossing count. Every table entry can therefore be loaded and read back through conversions. Streams long enough to wrap the crossing counter are practical, and crossing-zero markers can be placed mid-stream. These settings also bring within reach writes dropped in trigger mode, writes made after a return to setup mode, the non-writing select value, and candidates whose valid flag is clear.

// File: rtl/owf_pkg.sv
package owf_pkg;
    localparam int RANK_W  = 7;
    localparam int LOC_W   = 5;
    localparam int SID_W   = 4;
    localparam int PHI_W   = 8;
    localparam int ETA_W   = 6;
    localparam int PT_W    = 5;
    localparam int QUAL_W  = 3;
    localparam int BX_W    = 3;
    localparam int TDATA_W = 8;
    localparam int WORD_W  = 32;
    localparam int QP_AW   = RANK_W + 1;
    localparam int LOC_AW  = LOC_W + SID_W;
    localparam int PAYLD_W = 25;

    localparam logic [1:0] SEL_QP  = 2'd0;
    localparam logic [1:0] SEL_PHI = 2'd1;
    localparam logic [1:0] SEL_ETA = 2'd2;

    typedef enum logic [0:0] {
        ST_SETUP   = 1'b0,
        ST_TRIGGER = 1'b1
    } mode_state_t;
endpackage

// File: rtl/owf_mode_fsm.sv
module owf_mode_fsm
    import owf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_mode_i,
    output logic run_o,
    output logic wr_ok_o
);
    mode_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETUP:   if (trig_mode_i)  state_d = ST_TRIGGER;  // GO_TRIGGER
            ST_TRIGGER: if (!trig_mode_i) state_d = ST_SETUP;    // GO_SETUP
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SETUP;
        else        state_q <= state_d;
    end

    always_comb begin
        run_o   = 1'b0;
        wr_ok_o = 1'b0;
        unique case (state_q)
            ST_SETUP:   wr_ok_o = 1'b1;
            ST_TRIGGER: run_o   = 1'b1;
        endcase
    end

    AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_mode_i |=> run_o);  // R2
    AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        run_o != wr_ok_o);  // R2
endmodule

// File: rtl/owf_lut_bank.sv
module owf_lut_bank
    import owf_pkg::*;
#(
    parameter int N_CAND = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_ok,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_sel,
    input  logic [LOC_AW-1:0]             wr_addr,
    input  logic [TDATA_W-1:0]            wr_data,
    input  logic [N_CAND-1:0][QP_AW-1:0]  qp_addr,
    input  logic [N_CAND-1:0][LOC_AW-1:0] phi_addr,
    input  logic [N_CAND-1:0][LOC_AW-1:0] eta_addr,
    output logic [N_CAND-1:0][TDATA_W-1:0] qp_data,
    output logic [N_CAND-1:0][PHI_W-1:0]  phi_data,
    output logic [N_CAND-1:0][ETA_W-1:0]  eta_data
);
    localparam int QP_DEPTH  = 1 << QP_AW;
    localparam int LOC_DEPTH = 1 << LOC_AW;

    logic [TDATA_W-1:0] mem_qp  [QP_DEPTH];
    logic [PHI_W-1:0]   mem_phi [LOC_DEPTH];
    logic [ETA_W-1:0]   mem_eta [LOC_DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && wr_ok) begin
            case (wr_sel)
                SEL_QP:  mem_qp[wr_addr[QP_AW-1:0]] <= wr_data;
                SEL_PHI: mem_phi[wr_addr]           <= wr_data[PHI_W-1:0];
                SEL_ETA: mem_eta[wr_addr]           <= wr_data[ETA_W-1:0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < N_CAND; g++) begin : g_rd
        assign qp_data[g]  = mem_qp[qp_addr[g]];
        assign phi_data[g] = mem_phi[phi_addr[g]];
        assign eta_data[g] = mem_eta[eta_addr[g]];
    end

    AST_QP_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok && wr_en && wr_sel == SEL_QP) |=>
        mem_qp[$past(wr_addr[QP_AW-1:0])] == $past(mem_qp[wr_addr[QP_AW-1:0]]));  // R2
    AST_PHI_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok && wr_en && wr_sel == SEL_PHI) |=>
        mem_phi[$past(wr_addr)] == $past(mem_phi[wr_addr]));  // R2
endmodule

// File: rtl/owf_cand_lane.sv
module owf_cand_lane
    import owf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               s1_stb,
    input  logic [BX_W-1:0]    s1_bx,
    input  logic               s1_bc0,
    input  logic               s1_serr,
    input  logic [RANK_W-1:0]  rank,
    input  logic               vld,
    input  logic [LOC_W-1:0]   phi_loc,
    input  logic [LOC_W-1:0]   eta_loc,
    input  logic [SID_W-1:0]   sid,
    input  logic               halo,
    input  logic               sign,
    output logic [QP_AW-1:0]   qp_addr,
    output logic [LOC_AW-1:0]  phi_addr,
    output logic [LOC_AW-1:0]  eta_addr,
    input  logic [TDATA_W-1:0] qp_data,
    input  logic [PHI_W-1:0]   phi_data,
    input  logic [ETA_W-1:0]   eta_data,
    output logic [WORD_W-1:0]  word
);
    logic               s1_vld, s1_halo, s1_sign;
    logic [TDATA_W-1:0] s1_qp;
    logic [PHI_W-1:0]   s1_phi;
    logic [ETA_W-1:0]   s1_eta;
    logic [PAYLD_W-1:0] payload;

    assign qp_addr  = {vld, rank};
    assign phi_addr = {sid, phi_loc};
    assign eta_addr = {sid, eta_loc};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_halo <= 1'b0;
            s1_sign <= 1'b0;
            s1_qp   <= '0;
            s1_phi  <= '0;
            s1_eta  <= '0;
        end else if (take) begin
            s1_vld  <= vld;
            s1_halo <= halo;
            s1_sign <= sign;
            s1_qp   <= qp_data;
            s1_phi  <= phi_data;
            s1_eta  <= eta_data;
        end
    end

    always_comb begin
        payload = '0;
        if (s1_vld)
            payload = {1'b1, s1_sign, s1_halo, s1_eta,
                       s1_qp[TDATA_W-1 -: QUAL_W], s1_qp[PT_W-1:0], s1_phi};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      word <= '0;
        else if (s1_stb) word <= {1'b1, 1'b0, s1_serr, s1_bc0, s1_bx, payload};
    end

    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_stb && !s1_vld) |=> word[PAYLD_W-1:0] == '0);  // R8
endmodule

// File: rtl/lut_word_formatter.sv
module lut_word_formatter
    import owf_pkg::*;
#(
    parameter int N_CAND = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       trig_mode_i,
    input  logic                       wr_en_i,
    input  logic [1:0]                 wr_sel_i,
    input  logic [LOC_AW-1:0]          wr_addr_i,
    input  logic [TDATA_W-1:0]         wr_data_i,
    input  logic                       bc0_i,
    input  logic                       sync_err_i,
    input  logic                       in_valid_i,
    input  logic [N_CAND*RANK_W-1:0]   cand_rank_i,
    input  logic [N_CAND-1:0]          cand_vld_i,
    input  logic [N_CAND*LOC_W-1:0]    cand_phi_i,
    input  logic [N_CAND*LOC_W-1:0]    cand_eta_i,
    input  logic [N_CAND*SID_W-1:0]    cand_sid_i,
    input  logic [N_CAND-1:0]          cand_halo_i,
    input  logic [N_CAND-1:0]          cand_sign_i,
    output logic                       out_stb_o,
    output logic [N_CAND*WORD_W-1:0]   out_word_o
);
    logic              run, wr_ok, take;
    logic [BX_W-1:0]   bx_cnt, bx_now;
    logic              s1_stb, s1_bc0, s1_serr;
    logic [BX_W-1:0]   s1_bx;

    logic [N_CAND-1:0][QP_AW-1:0]   qp_addr;
    logic [N_CAND-1:0][LOC_AW-1:0]  phi_addr, eta_addr;
    logic [N_CAND-1:0][TDATA_W-1:0] qp_data;
    logic [N_CAND-1:0][PHI_W-1:0]   phi_data;
    logic [N_CAND-1:0][ETA_W-1:0]   eta_data;

    owf_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .trig_mode_i(trig_mode_i),
        .run_o(run), .wr_ok_o(wr_ok)
    );

    owf_lut_bank #(.N_CAND(N_CAND)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_en(wr_en_i),
        .wr_sel(wr_sel_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
        .qp_addr(qp_addr), .phi_addr(phi_addr), .eta_addr(eta_addr),
        .qp_data(qp_data), .phi_data(phi_data), .eta_data(eta_data)
    );

    assign take   = run && in_valid_i;
    assign bx_now = bc0_i ? '0 : bx_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bx_cnt    <= '0;
            s1_stb    <= 1'b0;
            s1_bx     <= '0;
            s1_bc0    <= 1'b0;
            s1_serr   <= 1'b0;
            out_stb_o <= 1'b0;
        end else begin
            bx_cnt    <= bx_now + 1'b1;
            s1_stb    <= take;
            out_stb_o <= s1_stb;
            if (take) begin
                s1_bx   <= bx_now;
                s1_bc0  <= bc0_i;
                s1_serr <= sync_err_i;
            end
        end
    end

    for (genvar k = 0; k < N_CAND; k++) begin : g_lane
        owf_cand_lane u_lane (
            .clk(clk), .rst_n(rst_n), .take(take), .s1_stb(s1_stb),
            .s1_bx(s1_bx), .s1_bc0(s1_bc0), .s1_serr(s1_serr),
            .rank(cand_rank_i[k*RANK_W +: RANK_W]),
            .vld(cand_vld_i[k]),
            .phi_loc(cand_phi_i[k*LOC_W +: LOC_W]),
            .eta_loc(cand_eta_i[k*LOC_W +: LOC_W]),
            .sid(cand_sid_i[k*SID_W +: SID_W]),
            .halo(cand_halo_i[k]), .sign(cand_sign_i[k]),
            .qp_addr(qp_addr[k]), .phi_addr(phi_addr[k]), .eta_addr(eta_addr[k]),
            .qp_data(qp_data[k]), .phi_data(phi_data[k]), .eta_data(eta_data[k]),
            .word(out_word_o[k*WORD_W +: WORD_W])
        );
    end

    AST_STB_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && run) |=> ##1 out_stb_o);  // R7
    AST_STB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb_o |-> $past(in_valid_i, 2));  // R7
    AST_BC0_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb_o && out_word_o[28]) |-> out_word_o[27:25] == 3'd0);  // R9
    AST_BX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb_o && $past(out_stb_o) && !out_word_o[28]) |->
        out_word_o[27:25] == 3'($past(out_word_o[27:25]) + 3'd1));  // R9
    AST_FRAME_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb_o |-> (out_word_o[31] && !out_word_o[30]));  // R10
endmodule

// File: tb/lut_word_formatter_bench.sv
module lut_word_formatter_bench;
    localparam int NC = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic trig_mode_i = 0, wr_en_i = 0, bc0_i = 0, sync_err_i = 0, in_valid_i = 0;
    logic [1:0]  wr_sel_i = 0;
    logic [8:0]  wr_addr_i = 0;
    logic [7:0]  wr_data_i = 0;
    logic [NC*7-1:0] cand_rank_i = 0;
    logic [NC-1:0]   cand_vld_i = 0, cand_halo_i = 0, cand_sign_i = 0;
    logic [NC*5-1:0] cand_phi_i = 0, cand_eta_i = 0;
    logic [NC*4-1:0] cand_sid_i = 0;
    logic            out_stb_o;
    logic [NC*32-1:0] out_word_o;

    lut_word_formatter #(.N_CAND(NC)) u_lut_word_formatter (.*);

    always #10 clk = ~clk;

    typedef struct { logic [NC*32-1:0] w; int cyc; } item_t;
    item_t sb[$];
    logic [7:0] m_qp [256];
    logic [7:0] m_phi[512];
    logic [5:0] m_eta[512];
    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [2:0] bcnt = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) bcnt <= 0;
        else        bcnt <= (bc0_i ? 3'd0 : bcnt) + 3'd1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic twr(input logic [1:0] sel, input int a, input logic [7:0] d, input bit in_setup);
        wr_en_i = 1; wr_sel_i = sel; wr_addr_i = 9'(a); wr_data_i = d;
        if (in_setup) begin
            if (sel == 2'd0) m_qp[a[7:0]] = d;
            if (sel == 2'd1) m_phi[a[8:0]] = d;
            if (sel == 2'd2) m_eta[a[8:0]] = d[5:0];
        end
        @(negedge clk);
        wr_en_i = 0;
    endtask

    // drive one candidate set; lane 0 rank forced when r0 >= 0
    task automatic send(input logic bc0, input logic serr, input logic [NC-1:0] vmask, input int r0);
        item_t it;
        logic [2:0] bx;
        bx = bc0 ? 3'd0 : bcnt;
        bc0_i = bc0; sync_err_i = serr; in_valid_i = 1; cand_vld_i = vmask;
        for (int k = 0; k < NC; k++) begin
            logic [6:0] rk; logic [4:0] pl, el; logic [3:0] sd; logic [7:0] qp;
            logic [31:0] w;
            rk = (k == 0 && r0 >= 0) ? 7'(r0) : 7'($urandom);
            pl = 5'($urandom); el = 5'($urandom); sd = 4'($urandom);
            cand_rank_i[k*7 +: 7] = rk; cand_phi_i[k*5 +: 5] = pl;
            cand_eta_i[k*5 +: 5] = el; cand_sid_i[k*4 +: 4] = sd;
            cand_halo_i[k] = 1'($urandom); cand_sign_i[k] = 1'($urandom);
            qp = m_qp[{vmask[k], rk}];
            w = '0; w[31] = 1; w[29] = serr; w[28] = bc0; w[27:25] = bx;
            if (vmask[k]) begin
                w[24] = 1; w[23] = cand_sign_i[k]; w[22] = cand_halo_i[k];
                w[21:16] = m_eta[{sd, el}]; w[15:13] = qp[7:5];
                w[12:8] = qp[4:0]; w[7:0] = m_phi[{sd, pl}];
            end
            it.w[k*32 +: 32] = w;
        end
        it.cyc = cyc + 2;
        if (trig_mode_i) sb.push_back(it);
        @(negedge clk);
        in_valid_i = 0; bc0_i = 0; sync_err_i = 0;
    endtask

    // monitor: scoreboard pop and field-wise compare
    always @(negedge clk) begin
        if (rst_n && out_stb_o) begin
            if (sb.size() == 0) begin
                chk("R7 strobe without accepted input", 32'(out_stb_o), 32'd0);
            end else begin
                item_t e;
                e = sb.pop_front();
                chk("R7 latency cycle", 32'(cyc), 32'(e.cyc));
                for (int k = 0; k < NC; k++) begin
                    logic [31:0] a, x;
                    a = out_word_o[k*32 +: 32]; x = e.w[k*32 +: 32];
                    chk("R5 phi field", 32'(a[7:0]), 32'(x[7:0]));
                    chk("R4 momentum/quality", 32'(a[15:8]), 32'(x[15:8]));
                    chk("R5 eta field", 32'(a[21:16]), 32'(x[21:16]));
                    if (!x[24]) chk("R8 invalid payload zero", 32'(a[24:0]), 32'd0);
                    chk("R9 crossing count", 32'(a[27:25]), 32'(x[27:25]));
                    chk("R10 frame bits", 32'(a[31:30]), 32'(x[31:30]));
                    chk("R6 full word", a, x);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) m_qp[i] = 'x;
        repeat (3) @(negedge clk);
        chk("R1 strobe in reset", 32'(out_stb_o), 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 strobe after reset", 32'(out_stb_o), 32'd0);
        chk("R1 words after reset", out_word_o[31:0] | out_word_o[63:32] |
            out_word_o[95:64] | out_word_o[127:96], 32'd0);
        // load tables in setup mode (R3 selects)
        for (int a = 0; a < 256; a++) twr(2'd0, a, 8'(a * 37 + 5), 1);
        for (int a = 0; a < 512; a++) twr(2'd1, a, 8'(a * 13 + 7), 1);
        for (int a = 0; a < 512; a++) twr(2'd2, a, 8'(a * 5 + 3), 1);
        // R3: select 3 writes nothing
        twr(2'd3, 9'h095, 8'hAA, 0);
        // R7: in_valid in setup gives no strobe
        send(0, 0, 4'hF, -1);
        repeat (3) @(negedge clk);
        trig_mode_i = 1;
        @(negedge clk);
        // R2: writes in trigger mode are dropped
        twr(2'd0, 9'h095, 8'h5A, 0);
        send(0, 0, 4'hF, 7'h15);            // rank 0x15 valid -> addr 0x95
        repeat (2) @(negedge clk);
        send(1, 0, 4'hF, -1);               // R9 restart
        for (int i = 0; i < 12; i++) send(0, i[0], 4'(i * 5 + 3), -1);  // stream, wrap
        send(0, 1, 4'h0, -1);               // R8 all invalid
        send(1, 1, 4'b1010, -1);
        for (int i = 0; i < 20; i++) begin
            send(i % 9 == 4, 0, 4'($urandom), -1);
            if (i % 3 == 0) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        // R2: back to setup, write now takes effect
        trig_mode_i = 0;
        @(negedge clk);
        twr(2'd0, 9'h095, 8'hC3, 1);
        send(0, 0, 4'hF, -1);               // ignored in setup
        trig_mode_i = 1;
        @(negedge clk);
        send(0, 0, 4'h1, 7'h15);
        repeat (5) @(negedge clk);
        chk("R7 all expected words seen", 32'(sb.size()), 32'd0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule